// File: doc/BRIEF.md
# Accumulator ALU with status flags

This block is the arithmetic and logic stage of an accumulator-based processor. Each clock it takes the accumulator value, an operand byte, the current flag byte and a 3-bit operation code, which is the operation field taken from bits 5..3 of the instruction. It works out the new accumulator value and a new flag byte. Both are captured in output registers.

Four operations are supported: subtract, subtract with borrow-in, bitwise AND, and bitwise OR. The subtractor is built as a borrow chain split at the nibble boundary. Because of this, the half-borrow, the full borrow and the signed overflow all come from the same arithmetic, and no second adder is needed. Any other operation code leaves the accumulator and the flags unchanged.

Top module: `acc_alu`

## Requirements
- R1: Results are registered. `result_o` and `flags_o` change only at a rising clock edge, and they show the inputs sampled at that edge.
- R2: With `op_code` = 3'b010 (subtract), `result_o` = (acc − operand) mod 256. Flag bit 0 of `flags_in` has no effect.
- R3: With `op_code` = 3'b011 (subtract with borrow), `result_o` = (acc − operand − `flags_in[0]`) mod 256.
- R4: For all four supported codes, `flags_o[7]` (sign) equals bit 7 of the result, and `flags_o[6]` (zero) is 1 exactly when the result is 0x00.
- R5: For both subtract codes, `flags_o[2]` is 1 when the signed difference (including the borrow-in for 3'b011) lies outside −128..+127.
- R6: For both subtract codes, `flags_o[1]` is 1. `flags_o[0]` is 1 when the unsigned minuend is smaller than the subtrahend plus the borrow-in.
- R7: For both subtract codes, `flags_o[4]` is 1 when the low nibble of acc is smaller than the low nibble of the operand plus the borrow-in.
- R8: With `op_code` = 3'b100 (AND), the result is acc & operand. `flags_o[4]` = 1, `flags_o[1]` = 0, `flags_o[0]` = 0, and `flags_o[2]` = 1 when the result has an even number of one bits.
- R9: With `op_code` = 3'b110 (OR), the result is acc | operand. `flags_o[4]`, `flags_o[1]` and `flags_o[0]` are all 0, and `flags_o[2]` gives even parity of the result.
- R10: For the supported codes, `flags_o[5]` and `flags_o[3]` are copied from `flags_in[5]` and `flags_in[3]`.
- R11: For any other code (000, 001, 101, 111), `result_o` = acc and `flags_o` = `flags_in`.
- R12: While `rst` is high at a rising edge, `result_o` and `flags_o` become 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 3 | Operation field (instruction bits 5..3) |
| acc_in | input | 8 | Accumulator value (minuend / first operand) |
| opnd_in | input | 8 | Operand byte |
| flags_in | input | 8 | Current flag byte; bit 0 is the carry/borrow-in |
| result_o | output | 8 | Registered new accumulator value |
| flags_o | output | 8 | Registered flag byte: S7 Z6 H4 P/V2 N1 C0, bits 5 and 3 passed through |

## Verification
Two parts of the subtractor can act in the same cycle: the borrow-in from the carry flag and the nibble-boundary borrow. The borrow-in can feed both the half-borrow and the full borrow at once, and it can also tip the signed overflow. The bench triggers this with directed pairs:
- 0x00 minus 0x00 with borrow-in set, where one incoming bit ripples through both nibbles.
- 0x80 minus 0x01, where overflow and half-borrow occur together without a full borrow.
- 0x00 minus 0x01.

A behavioural integer model then judges each flag separately on the next clock. Random operands over all eight codes cover the remaining mixtures.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  // Operation field encodings
  localparam logic [2:0] OP_SUB = 3'b010;
  localparam logic [2:0] OP_SBC = 3'b011;
  localparam logic [2:0] OP_AND = 3'b100;
  localparam logic [2:0] OP_OR  = 3'b110;

  // Flag byte bit positions
  localparam int FL_C  = 0;
  localparam int FL_N  = 1;
  localparam int FL_PV = 2;
  localparam int FL_X3 = 3;
  localparam int FL_H  = 4;
  localparam int FL_X5 = 5;
  localparam int FL_Z  = 6;
  localparam int FL_S  = 7;

  function automatic logic op_is_sub(input logic [2:0] op);
    return (op == OP_SUB) || (op == OP_SBC);
  endfunction

  function automatic logic op_is_logic(input logic [2:0] op);
    return (op == OP_AND) || (op == OP_OR);
  endfunction

endpackage

// File: rtl/acc_alu_sub.sv
// Borrow-chain subtractor split into low part, middle part and sign bit,
// so half-borrow, full borrow and overflow come from one chain.
module acc_alu_sub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         bin,
  output logic [W-1:0] diff,
  output logic         half_bw,
  output logic         full_bw,
  output logic         ovf
);
  localparam int LO  = W / 2;
  localparam int MID = W - 1 - LO;

  logic [LO:0]  lo_d;
  logic [MID:0] mid_d;
  logic [1:0]   top_d;

  always_comb begin
    lo_d  = {1'b0, a[LO-1:0]} - {1'b0, b[LO-1:0]} - {{LO{1'b0}}, bin};
    mid_d = {1'b0, a[W-2:LO]} - {1'b0, b[W-2:LO]} - {{MID{1'b0}}, lo_d[LO]};
    top_d = {1'b0, a[W-1]} - {1'b0, b[W-1]} - {1'b0, mid_d[MID]};
  end

  assign diff    = {top_d[0], mid_d[MID-1:0], lo_d[LO-1:0]};
  assign half_bw = lo_d[LO];
  assign full_bw = top_d[1];
  // Borrow into the sign bit differs from borrow out of it: signed overflow
  assign ovf     = mid_d[MID] ^ top_d[1];

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel_or,
  output logic [W-1:0] res,
  output logic         even_par
);
  assign res      = sel_or ? (a | b) : (a & b);
  assign even_par = ~^res;
endmodule

// File: rtl/acc_alu_flags.sv
// Selects the result and assembles the next flag byte.
module acc_alu_flags
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] sub_res,
  input  logic         half_bw,
  input  logic         full_bw,
  input  logic         ovf,
  input  logic [W-1:0] log_res,
  input  logic         even_par,
  input  logic [7:0]   flags_prev,
  output logic [W-1:0] res_nxt,
  output logic [7:0]   flags_nxt
);
  always_comb begin
    res_nxt   = acc;
    flags_nxt = flags_prev;
    if (op_is_sub(op)) begin
      res_nxt          = sub_res;
      flags_nxt[FL_H]  = half_bw;
      flags_nxt[FL_PV] = ovf;
      flags_nxt[FL_N]  = 1'b1;
      flags_nxt[FL_C]  = full_bw;
    end else if (op_is_logic(op)) begin
      res_nxt          = log_res;
      flags_nxt[FL_H]  = (op == OP_AND);
      flags_nxt[FL_PV] = even_par;
      flags_nxt[FL_N]  = 1'b0;
      flags_nxt[FL_C]  = 1'b0;
    end
    if (op_is_sub(op) || op_is_logic(op)) begin
      flags_nxt[FL_S] = res_nxt[W-1];
      flags_nxt[FL_Z] = (res_nxt == '0);
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   op_code,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opnd_in,
  input  logic [7:0]   flags_in,
  output logic [W-1:0] result_o,
  output logic [7:0]   flags_o
);
  logic [W-1:0] sub_res, log_res, res_nxt;
  logic         half_bw, full_bw, ovf, even_par, bin;
  logic [7:0]   flags_nxt;

  // Plain subtract ignores the carry flag
  assign bin = (op_code == OP_SBC) ? flags_in[FL_C] : 1'b0;

  acc_alu_sub #(.W(W)) u_sub (
    .a(acc_in), .b(opnd_in), .bin(bin),
    .diff(sub_res), .half_bw(half_bw), .full_bw(full_bw), .ovf(ovf)
  );

  acc_alu_logic #(.W(W)) u_logic (
    .a(acc_in), .b(opnd_in), .sel_or(op_code == OP_OR),
    .res(log_res), .even_par(even_par)
  );

  acc_alu_flags #(.W(W)) u_flags (
    .op(op_code), .acc(acc_in), .sub_res(sub_res), .half_bw(half_bw),
    .full_bw(full_bw), .ovf(ovf), .log_res(log_res), .even_par(even_par),
    .flags_prev(flags_in), .res_nxt(res_nxt), .flags_nxt(flags_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      result_o <= res_nxt;
      flags_o  <= flags_nxt;
    end
  end

  // R12: reset clears both output registers
  a_r12_reset_clear: assert property (@(posedge clk)
    rst |=> (result_o == '0 && flags_o == 8'h00));

  // R6: subtraction marks N
  a_r6_sub_sets_n: assert property (@(posedge clk) disable iff (rst)
    op_is_sub(op_code) |=> flags_o[FL_N]);

  // R8: AND forces H and clears N, C
  a_r8_and_flags: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_AND) |=> (flags_o[FL_H] && !flags_o[FL_N] && !flags_o[FL_C]));

  // R9: OR clears H, N, C
  a_r9_or_flags: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_OR) |=> (!flags_o[FL_H] && !flags_o[FL_N] && !flags_o[FL_C]));

  // R4: Z and S track the registered result
  a_r4_sign_zero: assert property (@(posedge clk) disable iff (rst)
    (op_is_sub(op_code) || op_is_logic(op_code)) |=>
      (flags_o[FL_Z] == (result_o == '0) && flags_o[FL_S] == result_o[W-1]));

  // R10: spare flag bits pass through
  a_r10_spare_bits: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (flags_o[FL_X5] == $past(flags_in[FL_X5]) &&
              flags_o[FL_X3] == $past(flags_in[FL_X3])));

  // R11: other codes leave accumulator and flags unchanged
  a_r11_pass_through: assert property (@(posedge clk) disable iff (rst)
    !(op_is_sub(op_code) || op_is_logic(op_code)) |=>
      (result_o == $past(acc_in) && flags_o == $past(flags_in)));

  // R6: a borrow can only occur when acc is not above the operand
  a_r6_borrow_bound: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_SUB && acc_in >= opnd_in) |=> !flags_o[FL_C]);

endmodule

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op_code = 3'b000;
  logic [7:0] acc_in = 8'h00, opnd_in = 8'h00, flags_in = 8'h00;
  logic [7:0] result_o, flags_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  acc_alu u_acc_alu (
    .clk(clk), .rst(rst), .op_code(op_code), .acc_in(acc_in),
    .opnd_in(opnd_in), .flags_in(flags_in), .result_o(result_o), .flags_o(flags_o)
  );

  function automatic logic [15:0] ref_model(input logic [2:0] op,
      input logic [7:0] a, input logic [7:0] b, input logic [7:0] f);
    int c, d, h, sd, ones;
    logic [7:0] r, fl;
    fl = {2'b00, f[5], 1'b0, f[3], 3'b000};
    c  = 0;
    case (op)
      3'b010, 3'b011: begin
        if (op == 3'b011) c = int'(f[0]);
        d  = int'(a) - int'(b) - c;
        h  = int'(a[3:0]) - int'(b[3:0]) - c;
        sd = int'($signed(a)) - int'($signed(b)) - c;
        r  = d[7:0];
        fl[7] = r[7];
        fl[6] = (r == 8'h00);
        fl[4] = (h < 0);
        fl[2] = (sd < -128) || (sd > 127);
        fl[1] = 1'b1;
        fl[0] = (d < 0);
      end
      3'b100, 3'b110: begin
        r = (op == 3'b100) ? (a & b) : (a | b);
        ones = $countones(r);
        fl[7] = r[7];
        fl[6] = (r == 8'h00);
        fl[4] = (op == 3'b100);
        fl[2] = (ones % 2 == 0);
      end
      default: begin
        r  = a;
        fl = f;
      end
    endcase
    return {r, fl};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Drive at the falling edge, sample 1 ns after the next rising edge
  task automatic step(input logic [2:0] op, input logic [7:0] a,
                      input logic [7:0] b, input logic [7:0] f);
    logic [15:0] e;
    logic [7:0]  prev_r, prev_f;
    string tr, tf;
    @(negedge clk);
    prev_r = result_o; prev_f = flags_o;
    op_code = op; acc_in = a; opnd_in = b; flags_in = f;
    #0.5;
    chk("R1", "result held before edge", result_o, prev_r);
    chk("R1", "flags held before edge", flags_o, prev_f);
    e = ref_model(op, a, b, f);
    @(posedge clk); #1;
    case (op)
      3'b010: begin tr = "R2"; tf = "sub"; end
      3'b011: begin tr = "R3"; tf = "sub"; end
      3'b100: begin tr = "R8"; tf = "R8"; end
      3'b110: begin tr = "R9"; tf = "R9"; end
      default: begin tr = "R11"; tf = "R11"; end
    endcase
    chk(tr, "result", result_o, e[15:8]);
    if (tf == "R11") begin
      chk("R11", "flags pass-through", flags_o, e[7:0]);
    end else begin
      chk("R4", "sign/zero", {6'b0, flags_o[7:6]}, {6'b0, e[7:6]});
      chk("R10", "spare bits", {6'b0, flags_o[5], flags_o[3]}, {6'b0, e[5], e[3]});
      if (tf == "sub") begin
        chk("R5", "overflow", {7'b0, flags_o[2]}, {7'b0, e[2]});
        chk("R6", "N and borrow", {6'b0, flags_o[1:0]}, {6'b0, e[1:0]});
        chk("R7", "half-borrow", {7'b0, flags_o[4]}, {7'b0, e[4]});
      end else begin
        chk(tf, "H/PV/N/C", {4'b0, flags_o[4], flags_o[2:0]}, {4'b0, e[4], e[2:0]});
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R12", "reset result", result_o, 8'h00);
    chk("R12", "reset flags", flags_o, 8'h00);
    @(negedge clk); rst = 1'b0;

    // Directed corner cases
    step(3'b010, 8'h80, 8'h01, 8'h00);  // overflow with half-borrow, no borrow
    step(3'b010, 8'h00, 8'h01, 8'h00);  // full and half borrow
    step(3'b011, 8'h00, 8'h00, 8'h01);  // borrow-in ripples through both nibbles
    step(3'b011, 8'h00, 8'h00, 8'h00);  // zero result
    step(3'b010, 8'h55, 8'h55, 8'h01);  // R2: borrow-in ignored
    step(3'b010, 8'h7F, 8'hFF, 8'h28);  // R10 spare bits set
    step(3'b011, 8'h7F, 8'h7F, 8'h29);  // R3 negative result from borrow-in
    step(3'b100, 8'hF0, 8'h0F, 8'h00);  // AND zero, even parity
    step(3'b100, 8'hFF, 8'h07, 8'hFF);  // AND odd parity
    step(3'b110, 8'h80, 8'h00, 8'hFF);  // OR sign
    step(3'b110, 8'h00, 8'h00, 8'h17);  // OR zero
    step(3'b000, 8'hA5, 8'h3C, 8'hD7);  // R11
    step(3'b111, 8'h12, 8'h34, 8'h00);  // R11
    step(3'b101, 8'h00, 8'hFF, 8'hFF);  // R11

    // Random sweep over all codes
    for (int i = 0; i < 600; i++)
      step(3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom), 8'($urandom));

    // Reset in the middle of a run
    @(negedge clk);
    rst = 1'b1; op_code = 3'b010; acc_in = 8'h00; opnd_in = 8'h01;
    @(posedge clk); #1;
    chk("R12", "mid-run reset result", result_o, 8'h00);
    chk("R12", "mid-run reset flags", flags_o, 8'h00);
    @(negedge clk); rst = 1'b0;
    step(3'b011, 8'h10, 8'h01, 8'h01);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule